// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate Lanes

This block is a SIMD datapath stage. It takes two 128-bit source vectors and a 128-bit accumulator vector. From each source it takes one 64-bit half and splits it into narrow signed elements. Each pair of elements with the same index is multiplied and the product is doubled. The doubled product is clamped to the signed range of twice the element width. It is then added to the wide accumulator lane with the same index, and the sum is clamped to that range again.

A two-bit size code picks 16-bit or 32-bit elements. The other two codes are rejected as illegal. A half-select bit picks the lower or upper half of the sources. A mode bit picks between vector operation, where every lane of the half is used, and scalar operation, where only element 0 of the lower half is used.

The result is registered one cycle after a valid input. The result comes with a per-lane mask that shows which lanes clamped. A sticky flag records that some lane clamped at some time since the flag was last cleared. A synchronous clear input resets the flag.

Top module: `sqdmac_lanes`

## Requirements
- R1: Size code 2'b01 selects 16-bit source elements. Lane i (i = 0..3) uses source bits [16i+15:16i] of the selected half, and accumulator and result bits [32i+31:32i].
- R2: Size codes 2'b00 and 2'b11 are illegal. An accepted operation with either code raises out_illegal, leaves result unchanged, drives lane_sat to zero and leaves sat_sticky unchanged, apart from a clear.
- R3: Size code 2'b10 selects 32-bit source elements. Lane i (i = 0..1) uses source bits [32i+31:32i] of the selected half, and accumulator and result bits [64i+63:64i].
- R4: In vector mode, upper_half = 0 takes the elements from source bits 63:0 and upper_half = 1 takes them from bits 127:64. The accumulator lanes always start at bit 0.
- R5: Each lane forms 2*a*b as a signed value and clamps it to the double-width signed range. Only the case where both operands are the most negative value clamps, and it gives the double-width maximum.
- R6: The clamped product is added to the signed accumulator lane. A sum outside the double-width range becomes the maximum when it is too large and the minimum when it is too small.
- R7: In scalar mode (scalar_mode = 1) only lane 0 is computed, from the lower half whatever upper_half is. The result bits above that lane are zero, and only lane_sat[0] can be set.
- R8: lane_sat bit i is set when either clamping step fired in lane i of the current legal operation. Such an operation sets sat_sticky, and the flag then stays set until a clear.
- R9: sat_clear forces sat_sticky to 0 at the next edge. This takes priority over a set in the same cycle.
- R10: An operation accepted with in_valid is due on the next clock edge: out_valid is high for exactly that cycle. While in_valid is low, result, lane_sat and out_illegal hold their values.
- R11: Reset drives out_valid, out_illegal, result, lane_sat and sat_sticky to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts an operation this cycle |
| size_code | input | 2 | Element size code: 01 = 16-bit, 10 = 32-bit, others illegal |
| upper_half | input | 1 | Selects the source half in vector mode (1 = bits 127:64) |
| scalar_mode | input | 1 | Processes a single lane from element 0 of the lower half |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| sat_clear | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| out_illegal | output | 1 | The last accepted operation used a reserved size code |
| result | output | 128 | Saturated accumulate result |
| lane_sat | output | 4 | Lanes that clamped in the last legal operation |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Every output is due one rising edge after the cycle that presents the operation or the clear. Nothing in the block is combinational from input to output. The bench drives inputs on the falling edge and updates its model for the next rising edge. It then compares all five outputs on the following falling edge, so each comparison lands exactly one register stage after its stimulus. Idle cycles are compared the same way, which confirms that values hold and that the flag stays set with no new operation.

// File: rtl/sqd_pkg.sv
package sqd_pkg;

    typedef enum logic [1:0] {
        SZ_RSV_LO = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_RSV_HI = 2'b11
    } sqd_size_e;

endpackage

// File: rtl/sqd_lane.sv
module sqd_lane #(
    parameter int EW = 16
) (
    input  logic [EW-1:0]   op_a,
    input  logic [EW-1:0]   op_b,
    input  logic [2*EW-1:0] acc,
    output logic [2*EW-1:0] sum,
    output logic            sat
);
    localparam int DW = 2 * EW;
    localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [EW-1:0] NMIN = {1'b1, {(EW-1){1'b0}}};

    logic signed [DW-1:0] a_x;
    logic signed [DW-1:0] b_x;
    logic signed [DW-1:0] prod;
    logic        [DW:0]   dbl;
    logic                 prod_ovf;
    logic        [DW-1:0] prod_sat;
    logic        [DW:0]   tot;
    logic                 tot_ovf;

    always_comb begin
        a_x      = $signed({{EW{op_a[EW-1]}}, op_a});
        b_x      = $signed({{EW{op_b[EW-1]}}, op_b});
        prod     = a_x * b_x;
        dbl      = {prod, 1'b0};
        prod_ovf = dbl[DW] ^ dbl[DW-1];
        if (prod_ovf) begin
            prod_sat = dbl[DW] ? WMIN : WMAX;
        end else begin
            prod_sat = dbl[DW-1:0];
        end
        tot     = {prod_sat[DW-1], prod_sat} + {acc[DW-1], acc};
        tot_ovf = tot[DW] ^ tot[DW-1];
        if (tot_ovf) begin
            sum = tot[DW] ? WMIN : WMAX;
        end else begin
            sum = tot[DW-1:0];
        end
        sat = prod_ovf | tot_ovf;
        AST_PROD_ONLY_MIN: assert (!(prod_ovf === 1'b1) || (op_a == NMIN && op_b == NMIN && prod_sat == WMAX)) else $error("product clamp outside min*min"); // R5
    end

endmodule

// File: rtl/sqd_bank.sv
module sqd_bank #(
    parameter int HALF_W = 64,
    parameter int EW     = 16,
    parameter int NL     = HALF_W / EW
) (
    input  logic [HALF_W-1:0]   half_a,
    input  logic [HALF_W-1:0]   half_b,
    input  logic [2*HALF_W-1:0] acc,
    output logic [2*HALF_W-1:0] res,
    output logic [NL-1:0]       sat
);
    localparam int DW = 2 * EW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        sqd_lane #(.EW(EW)) u_lane (
            .op_a (half_a[g*EW +: EW]),
            .op_b (half_b[g*EW +: EW]),
            .acc  (acc[g*DW +: DW]),
            .sum  (res[g*DW +: DW]),
            .sat  (sat[g])
        );
    end

endmodule

// File: rtl/sqd_opsel.sv
module sqd_opsel #(
    parameter int VEC_W  = 128,
    parameter int HALF_W = VEC_W / 2
) (
    input  logic [VEC_W-1:0]  src,
    input  logic              upper,
    input  logic              scalar,
    output logic [HALF_W-1:0] half
);
    always_comb begin
        if (upper && !scalar) begin
            half = src[VEC_W-1:HALF_W];
        end else begin
            half = src[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/sqdmac_lanes.sv
module sqdmac_lanes
    import sqd_pkg::*;
#(
    parameter int VEC_W     = 128,
    parameter int NARROW_EW = 16,
    parameter int WIDE_EW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       size_code,
    input  logic             upper_half,
    input  logic             scalar_mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    input  logic             sat_clear,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] result,
    output logic [(VEC_W/2)/NARROW_EW-1:0] lane_sat,
    output logic             sat_sticky
);
    localparam int HALF_W = VEC_W / 2;
    localparam int NL_N   = HALF_W / NARROW_EW;
    localparam int NL_W   = HALF_W / WIDE_EW;
    localparam int MASK_W = NL_N;
    localparam logic [VEC_W-1:0] KEEP_N = {{(VEC_W-2*NARROW_EW){1'b0}}, {(2*NARROW_EW){1'b1}}};
    localparam logic [VEC_W-1:0] KEEP_W = {{(VEC_W-2*WIDE_EW){1'b0}}, {(2*WIDE_EW){1'b1}}};
    localparam logic [MASK_W-1:0] LANE0 = {{(MASK_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [VEC_W-1:0]  res;
        logic [MASK_W-1:0] msk;
        logic              stk;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [HALF_W-1:0] half_a, half_b;
    logic [VEC_W-1:0]  res_n, res_w;
    logic [NL_N-1:0]   sat_n;
    logic [NL_W-1:0]   sat_w;
    logic              legal_d;
    logic              narrow_d;
    logic [VEC_W-1:0]  pick_res_d;
    logic [MASK_W-1:0] pick_msk_d;

    sqd_opsel #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_sel_a (
        .src(src_a), .upper(upper_half), .scalar(scalar_mode), .half(half_a)
    );
    sqd_opsel #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_sel_b (
        .src(src_b), .upper(upper_half), .scalar(scalar_mode), .half(half_b)
    );

    sqd_bank #(.HALF_W(HALF_W), .EW(NARROW_EW), .NL(NL_N)) u_bank_n (
        .half_a(half_a), .half_b(half_b), .acc(acc_in), .res(res_n), .sat(sat_n)
    );
    sqd_bank #(.HALF_W(HALF_W), .EW(WIDE_EW), .NL(NL_W)) u_bank_w (
        .half_a(half_a), .half_b(half_b), .acc(acc_in), .res(res_w), .sat(sat_w)
    );

    always_comb begin
        stage_d  = stage_q;
        narrow_d = (size_code == SZ_HALF);
        legal_d  = narrow_d || (size_code == SZ_WORD);
        if (narrow_d) begin
            pick_res_d = res_n;
            pick_msk_d = sat_n;
        end else begin
            pick_res_d = res_w;
            pick_msk_d = {{(MASK_W-NL_W){1'b0}}, sat_w};
        end
        if (scalar_mode) begin
            pick_res_d = pick_res_d & (narrow_d ? KEEP_N : KEEP_W);
            pick_msk_d = pick_msk_d & LANE0;
        end
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.ill = !legal_d;
            if (legal_d) begin
                stage_d.res = pick_res_d;
                stage_d.msk = pick_msk_d;
                if (|pick_msk_d) begin
                    stage_d.stk = 1'b1;
                end
            end else begin
                stage_d.msk = '0;
            end
        end
        if (sat_clear) begin
            stage_d.stk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.vld;
    assign out_illegal = stage_q.ill;
    assign result      = stage_q.res;
    assign lane_sat    = stage_q.msk;
    assign sat_sticky  = stage_q.stk;

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> ($stable(result) && lane_sat == '0)) else $error("illegal op changed result"); // R2
    AST_STICKY_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_clear) |=> (lane_sat == '0 || out_illegal || sat_sticky)) else $error("mask set without flag"); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clear) |=> sat_sticky) else $error("flag dropped without clear"); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clear |=> !sat_sticky) else $error("clear did not win"); // R9
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid not delivered"); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(lane_sat))) else $error("idle cycle changed outputs"); // R10
    AST_SCALAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar_mode && size_code == SZ_HALF) |=> (result[VEC_W-1:2*NARROW_EW] == '0 && lane_sat[MASK_W-1:1] == '0)) else $error("scalar upper bits nonzero"); // R7

endmodule

// File: tb/sim_sqdmac_lanes.sv
`timescale 1ns/1ps
module sim_sqdmac_lanes;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   size_code;
    logic         upper_half;
    logic         scalar_mode;
    logic [127:0] src_a, src_b, acc_in;
    logic         sat_clear;
    logic         out_valid, out_illegal, sat_sticky;
    logic [127:0] result;
    logic [3:0]   lane_sat;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    logic         e_vld, e_ill, e_stk;
    logic [127:0] e_res;
    logic [3:0]   e_msk;

    always #2.5 clk = ~clk;

    sqdmac_lanes u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
        .upper_half(upper_half), .scalar_mode(scalar_mode), .src_a(src_a),
        .src_b(src_b), .acc_in(acc_in), .sat_clear(sat_clear),
        .out_valid(out_valid), .out_illegal(out_illegal), .result(result),
        .lane_sat(lane_sat), .sat_sticky(sat_sticky)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(out_valid === e_vld, tag, "out_valid", 128'(out_valid), 128'(e_vld));
        check(out_illegal === e_ill, tag, "out_illegal", 128'(out_illegal), 128'(e_ill));
        check(result === e_res, tag, "result", result, e_res);
        check(lane_sat === e_msk, tag, "lane_sat", 128'(lane_sat), 128'(e_msk));
        check(sat_sticky === e_stk, tag, "sat_sticky", 128'(sat_sticky), 128'(e_stk));
    endtask

    function automatic void model(input logic [1:0] sz, input logic up, input logic sc,
                                  input logic [127:0] a, input logic [127:0] b,
                                  input logic [127:0] acc,
                                  output logic [127:0] r, output logic [3:0] m);
        int ew, n;
        logic [63:0] ha, hb;
        ew = (sz == 2'b01) ? 16 : 32;
        n  = sc ? 1 : 64 / ew;
        ha = (sc || !up) ? a[63:0] : a[127:64];
        hb = (sc || !up) ? b[63:0] : b[127:64];
        r = '0;
        m = '0;
        for (int e = 0; e < n; e++) begin
            logic signed [127:0] x, y, c, p, s, mx, mn;
            logic [127:0] t;
            bit hit;
            hit = 0;
            t = 128'(ha) >> (e * ew);
            if (ew == 16) x = $signed(t[15:0]); else x = $signed(t[31:0]);
            t = 128'(hb) >> (e * ew);
            if (ew == 16) y = $signed(t[15:0]); else y = $signed(t[31:0]);
            t = acc >> (e * 2 * ew);
            if (ew == 16) c = $signed(t[31:0]); else c = $signed(t[63:0]);
            mx = (128'sd1 <<< (2 * ew - 1)) - 128'sd1;
            mn = -mx - 128'sd1;
            p = 128'sd2 * x * y;
            if (p > mx) begin p = mx; hit = 1; end
            if (p < mn) begin p = mn; hit = 1; end
            s = c + p;
            if (s > mx) begin s = mx; hit = 1; end
            if (s < mn) begin s = mn; hit = 1; end
            t = 128'(s) & ((128'd1 << (2 * ew)) - 128'd1);
            r = r | (t << (e * 2 * ew));
            if (hit) m[e] = 1'b1;
        end
    endfunction

    task automatic step(input logic [1:0] sz, input logic up, input logic sc,
                        input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                        input logic vld, input logic clr, input string tag);
        logic [127:0] r;
        logic [3:0]   m;
        size_code = sz; upper_half = up; scalar_mode = sc;
        src_a = a; src_b = b; acc_in = acc; in_valid = vld; sat_clear = clr;
        e_vld = vld;
        if (vld) begin
            e_ill = (sz == 2'b00) || (sz == 2'b11);
            if (!e_ill) begin
                model(sz, up, sc, a, b, acc, r, m);
                e_res = r;
                e_msk = m;
                if (m != 0) e_stk = 1'b1;
            end else begin
                e_msk = '0;
            end
        end
        if (clr) e_stk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        rst_n = 1'b0; in_valid = 0; size_code = 0; upper_half = 0; scalar_mode = 0;
        src_a = '0; src_b = '0; acc_in = '0; sat_clear = 0;
        e_vld = 0; e_ill = 0; e_stk = 0; e_res = '0; e_msk = '0;
        repeat (3) @(negedge clk);
        compare("R11");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R11");

        // R1 small 16-bit values, lower half
        step(2'b01, 0, 0, {64'h0, 64'h0004_0003_FFFE_0002}, {64'h0, 64'h0005_FFFF_0007_0003},
             128'h0000_0000_0000_0064_FFFF_FFFF_0000_0010, 1, 0, "R1");
        // R4 upper half
        step(2'b01, 1, 0, {64'h0001_0002_0003_0004, 64'h7777_7777_7777_7777},
             {64'h0010_0020_0030_0040, 64'h1111_1111_1111_1111}, '0, 1, 0, "R4");
        // R3 32-bit lanes, both halves
        step(2'b10, 0, 0, {64'h0, 64'hFFFF_FFFF_0001_0000}, {64'h0, 64'h0000_0003_0001_0000},
             {64'h1, 64'h5}, 1, 0, "R3");
        step(2'b10, 1, 0, {64'h0000_1000_FFFF_FFFE, 64'h0}, {64'h0000_1000_0000_0009, 64'h0},
             '0, 1, 0, "R3/R4");
        // R5 min*min on all 16-bit lanes
        step(2'b01, 0, 0, {64'h0, {4{16'h8000}}}, {64'h0, {4{16'h8000}}}, '0, 1, 0, "R5");
        // R8 flag holds over idle cycles
        step(2'b01, 0, 0, '0, '0, '0, 0, 0, "R8/R10");
        step(2'b10, 0, 0, rnd128(), rnd128(), rnd128(), 0, 0, "R8/R10");
        // R9 clear beats set in the same cycle
        step(2'b10, 0, 0, {64'h0, {2{32'h8000_0000}}}, {64'h0, {2{32'h8000_0000}}}, '0, 1, 1, "R9");
        step(2'b10, 0, 0, '0, '0, '0, 0, 1, "R9");
        // R6 positive accumulate overflow and negative underflow
        step(2'b01, 0, 0, {64'h0, 64'h0000_0000_8000_4000}, {64'h0, 64'h0000_0000_7FFF_4000},
             {64'h0, 64'h0000_0000_0000_0000_8000_0000_7FFF_0000} , 1, 0, "R6");
        step(2'b01, 0, 0, '0, '0, '0, 0, 1, "R9");
        step(2'b10, 0, 0, {64'h0, 64'h7FFF_FFFF_7FFF_FFFF}, {64'h0, 64'h7FFF_FFFF_8000_0001},
             {64'h7FFF_0000_0000_0000, 64'h8000_0000_0000_0000}, 1, 0, "R6");
        step(2'b10, 0, 0, '0, '0, '0, 0, 1, "R9");
        // R7 scalar ignores upper_half and upper lanes
        step(2'b01, 1, 1, {{7{16'h1234}}, 16'h0003}, {{7{16'h5678}}, 16'h0004}, {{3{32'hFFFF}}, 32'h0000_0001}, 1, 0, "R7");
        step(2'b10, 1, 1, {{3{32'h8000_0000}}, 32'h8000_0000}, {{3{32'h8000_0000}}, 32'h8000_0000}, rnd128(), 1, 0, "R7");
        step(2'b01, 0, 0, '0, '0, '0, 0, 1, "R9");
        // R2 reserved codes with data that would clamp
        step(2'b00, 0, 0, {64'h0, {4{16'h8000}}}, {64'h0, {4{16'h8000}}}, '0, 1, 0, "R2");
        step(2'b11, 1, 0, {8{16'h8000}}, {8{16'h8000}}, rnd128(), 1, 0, "R2");
        step(2'b01, 0, 0, '0, '0, '0, 0, 0, "R2/R10");
        // randomised mix
        for (int i = 0; i < 60; i++) begin
            logic [1:0] sz;
            sz = ($urandom % 5 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'b01 : 2'b10);
            if (i % 7 == 3) begin
                step(sz, 1'($urandom), 1'($urandom), {8{16'h8000}}, {8{16'h8000}}, rnd128(), 1'($urandom), 1'($urandom % 4 == 0), "R1/R3/R8");
            end else begin
                step(sz, 1'($urandom), 1'($urandom), rnd128(), rnd128(), rnd128(), 1'($urandom % 4 != 0), 1'($urandom % 6 == 0), "R1/R3/R6");
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule